// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block is the CPU-side sequencer that turns an accepted interrupt request into an exception entry. It holds a level request until the core signals a boundary between two instructions, so an interrupt never splits an instruction. At that boundary, in a single clock edge, it does four things. It writes the source code into two event registers. It keeps a copy of the status word and of the address of the next unexecuted instruction. It produces a new status word with the block, privileged-mode and register-bank bits forced high. It issues a one-cycle fetch redirect to the vector base plus a fixed handler offset.

The redirect replaces the old stream at once, with no delay slot. The interrupt mask field in the status word is carried over unchanged. While the block bit of the incoming status word is high, the sequencer takes no request. For one cycle after an entry it also ignores requests, so the core has time to commit the new status word.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst_n` is low, `redirect` is 0 and every saved, event, status and fetch output reads zero.
- R2: An entry happens at a clock edge where the sequencer is idle, `irq_req`=1, `insn_brk`=1 and `sr_in[28]` (block bit)=0. The following cycle `redirect`=1 for exactly one cycle, and a request present during that redirect cycle is not taken.
- R3: A request with `insn_brk`=0 never causes a redirect; the request waits for a boundary.
- R4: On entry `evt_a` takes `irq_code` and `evt_b` takes `irq_code` zero-extended to its wider width.
- R5: On entry `saved_sr` takes `sr_in` and `saved_pc` takes `pc_next` as sampled at the entry edge.
- R6: On entry `sr_new` equals `sr_in` with bit 30 (privileged mode), bit 29 (register bank) and bit 28 (block) set to 1. Every other bit, including the mask field `[7:4]`, is unchanged.
- R7: On entry `fetch_addr` equals `vbr_in` + 0x600 (modulo 2^32), sampled at the entry edge.
- R8: When `sr_in[28]`=1 no entry happens, whatever `irq_req` and `insn_brk` are.
- R9: All saved, event, status and fetch outputs change only at an entry edge, in the same cycle `redirect` rises, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Accepted interrupt request (level) |
| irq_code | input | 12 | Source event code |
| insn_brk | input | 1 | Instruction-boundary strobe |
| sr_in | input | 32 | Current status word |
| pc_next | input | 32 | Address of next unexecuted instruction |
| vbr_in | input | 32 | Vector base |
| evt_a | output | 12 | First event register |
| evt_b | output | 16 | Second event register (zero-extended code) |
| saved_sr | output | 32 | Saved status word |
| saved_pc | output | 32 | Saved program counter |
| sr_new | output | 32 | Status word to load on entry |
| fetch_addr | output | 32 | Handler fetch address |
| redirect | output | 1 | One-cycle fetch redirect strobe |

## Verification
Every result of an entry is due one clock after the edge at which the request, the boundary strobe and a clear block bit are all present. `redirect`, both event registers, both saved copies, the new status and the fetch address become valid together at that point. The bench drives inputs on the falling edge and samples all outputs 1 ns after the next rising edge. Its model advances by exactly one edge per step, so each expected value is compared in the cycle it is due. Between entries, the same per-step comparison confirms that nothing moved.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
   typedef enum logic [0:0] {
      SEQ_IDLE  = 1'b0,
      SEQ_ENTER = 1'b1
   } seq_state_e;

   localparam int unsigned DEF_XLEN   = 32;
   localparam int unsigned DEF_BLK    = 28;
   localparam int unsigned DEF_BNK    = 29;
   localparam int unsigned DEF_PRIV   = 30;
   localparam int unsigned DEF_MSK_LO = 4;
   localparam int unsigned DEF_MSK_W  = 4;
endpackage

// File: rtl/irq_take_ctl.sv
module irq_take_ctl
   import irq_entry_pkg::*;
#(
   parameter int unsigned XLEN    = DEF_XLEN,
   parameter int unsigned BLK_POS = DEF_BLK
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            irq_req,
   input  logic            insn_brk,
   input  logic [XLEN-1:0] sr_cur,
   output logic            take,
   output logic            redirect
);
   seq_state_e state_q, state_d;

   always_comb begin
      take    = (state_q == SEQ_IDLE) && irq_req && insn_brk && !sr_cur[BLK_POS];
      state_d = take ? SEQ_ENTER : SEQ_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= SEQ_IDLE;
      else        state_q <= state_d;
   end

   assign redirect = (state_q == SEQ_ENTER);
endmodule

// File: rtl/irq_sr_build.sv
module irq_sr_build
   import irq_entry_pkg::*;
#(
   parameter int unsigned XLEN     = DEF_XLEN,
   parameter int unsigned BLK_POS  = DEF_BLK,
   parameter int unsigned BNK_POS  = DEF_BNK,
   parameter int unsigned PRIV_POS = DEF_PRIV
) (
   input  logic [XLEN-1:0] sr_cur,
   output logic [XLEN-1:0] sr_set
);
   for (genvar i = 0; i < XLEN; i++) begin : g_bit
      if (i == BLK_POS || i == BNK_POS || i == PRIV_POS) begin : g_force
         assign sr_set[i] = 1'b1;
      end else begin : g_keep
         assign sr_set[i] = sr_cur[i];
      end
   end
endmodule

// File: rtl/irq_ctx_regs.sv
module irq_ctx_regs
   import irq_entry_pkg::*;
#(
   parameter int unsigned XLEN    = DEF_XLEN,
   parameter int unsigned CODE_W  = 12,
   parameter int unsigned EVTB_W  = 16,
   parameter logic [31:0] VEC_OFF = 32'h0000_0600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [CODE_W-1:0] irq_code,
   input  logic [XLEN-1:0]   sr_cur,
   input  logic [XLEN-1:0]   sr_set,
   input  logic [XLEN-1:0]   pc_next,
   input  logic [XLEN-1:0]   vbr_in,
   output logic [CODE_W-1:0] evt_a,
   output logic [EVTB_W-1:0] evt_b,
   output logic [XLEN-1:0]   saved_sr,
   output logic [XLEN-1:0]   saved_pc,
   output logic [XLEN-1:0]   sr_new,
   output logic [XLEN-1:0]   fetch_addr
);
   localparam logic [XLEN-1:0] OFF_X = XLEN'(VEC_OFF);

   logic [EVTB_W-1:0] code_wide;

   if (EVTB_W == CODE_W) begin : g_evt_same
      assign code_wide = irq_code;
   end else begin : g_evt_ext
      assign code_wide = {{(EVTB_W-CODE_W){1'b0}}, irq_code};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_a      <= '0;
         evt_b      <= '0;
         saved_sr   <= '0;
         saved_pc   <= '0;
         sr_new     <= '0;
         fetch_addr <= '0;
      end else if (take) begin
         evt_a      <= irq_code;
         evt_b      <= code_wide;
         saved_sr   <= sr_cur;
         saved_pc   <= pc_next;
         sr_new     <= sr_set;
         fetch_addr <= vbr_in + OFF_X;
      end
   end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_entry_pkg::*;
#(
   parameter int unsigned XLEN     = DEF_XLEN,
   parameter int unsigned CODE_W   = 12,
   parameter int unsigned EVTB_W   = 16,
   parameter int unsigned BLK_POS  = DEF_BLK,
   parameter int unsigned BNK_POS  = DEF_BNK,
   parameter int unsigned PRIV_POS = DEF_PRIV,
   parameter logic [31:0] VEC_OFF  = 32'h0000_0600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic [CODE_W-1:0] irq_code,
   input  logic              insn_brk,
   input  logic [XLEN-1:0]   sr_in,
   input  logic [XLEN-1:0]   pc_next,
   input  logic [XLEN-1:0]   vbr_in,
   output logic [CODE_W-1:0] evt_a,
   output logic [EVTB_W-1:0] evt_b,
   output logic [XLEN-1:0]   saved_sr,
   output logic [XLEN-1:0]   saved_pc,
   output logic [XLEN-1:0]   sr_new,
   output logic [XLEN-1:0]   fetch_addr,
   output logic              redirect
);
   if (EVTB_W < CODE_W) begin : g_bad_evt
      $error("EVTB_W must be at least CODE_W");
   end
   if (BLK_POS >= XLEN || BNK_POS >= XLEN || PRIV_POS >= XLEN) begin : g_bad_pos
      $error("status bit position outside XLEN");
   end
   if (BLK_POS == BNK_POS || BLK_POS == PRIV_POS || BNK_POS == PRIV_POS) begin : g_dup_pos
      $error("status bit positions must differ");
   end

   logic            take;
   logic [XLEN-1:0] sr_set;

   irq_take_ctl #(.XLEN(XLEN), .BLK_POS(BLK_POS)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_req  (irq_req),
      .insn_brk (insn_brk),
      .sr_cur   (sr_in),
      .take     (take),
      .redirect (redirect)
   );

   irq_sr_build #(
      .XLEN(XLEN), .BLK_POS(BLK_POS), .BNK_POS(BNK_POS), .PRIV_POS(PRIV_POS)
   ) u_sr (
      .sr_cur (sr_in),
      .sr_set (sr_set)
   );

   irq_ctx_regs #(
      .XLEN(XLEN), .CODE_W(CODE_W), .EVTB_W(EVTB_W), .VEC_OFF(VEC_OFF)
   ) u_ctx (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .irq_code   (irq_code),
      .sr_cur     (sr_in),
      .sr_set     (sr_set),
      .pc_next    (pc_next),
      .vbr_in     (vbr_in),
      .evt_a      (evt_a),
      .evt_b      (evt_b),
      .saved_sr   (saved_sr),
      .saved_pc   (saved_pc),
      .sr_new     (sr_new),
      .fetch_addr (fetch_addr)
   );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned CODE_W   = 12,
   parameter int unsigned EVTB_W   = 16,
   parameter int unsigned BLK_POS  = 28,
   parameter int unsigned BNK_POS  = 29,
   parameter int unsigned PRIV_POS = 30,
   parameter int unsigned MSK_LO   = 4,
   parameter int unsigned MSK_W    = 4,
   parameter logic [31:0] VEC_OFF  = 32'h0000_0600
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_req,
   input logic              insn_brk,
   input logic [CODE_W-1:0] irq_code,
   input logic [XLEN-1:0]   sr_in,
   input logic [XLEN-1:0]   pc_next,
   input logic [XLEN-1:0]   vbr_in,
   input logic [CODE_W-1:0] evt_a,
   input logic [EVTB_W-1:0] evt_b,
   input logic [XLEN-1:0]   saved_sr,
   input logic [XLEN-1:0]   saved_pc,
   input logic [XLEN-1:0]   sr_new,
   input logic [XLEN-1:0]   fetch_addr,
   input logic              redirect
);
   AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> !redirect); // R2
   AST_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_brk |=> !redirect); // R3
   AST_EVT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> (evt_b == EVTB_W'(evt_a) && evt_a == $past(irq_code))); // R4
   AST_SAVE_PC: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> (saved_pc == $past(pc_next) && saved_sr == $past(sr_in))); // R5
   AST_STATUS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> (sr_new[BLK_POS] && sr_new[BNK_POS] && sr_new[PRIV_POS])); // R6
   AST_MASK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> (sr_new[MSK_LO +: MSK_W] == saved_sr[MSK_LO +: MSK_W])); // R6
   AST_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> (fetch_addr == $past(vbr_in) + XLEN'(VEC_OFF))); // R7
   AST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      sr_in[BLK_POS] |=> !redirect); // R8
   AST_HOLD_CTX: assert property (@(posedge clk) disable iff (!rst_n)
      !redirect |-> ($stable(saved_pc) && $stable(saved_sr) && $stable(fetch_addr)
                     && $stable(sr_new) && $stable(evt_a))); // R9
endmodule

bind irq_entry_seq irq_entry_chk #(
   .XLEN(XLEN), .CODE_W(CODE_W), .EVTB_W(EVTB_W), .BLK_POS(BLK_POS),
   .BNK_POS(BNK_POS), .PRIV_POS(PRIV_POS), .VEC_OFF(VEC_OFF)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_brk(insn_brk),
   .irq_code(irq_code), .sr_in(sr_in), .pc_next(pc_next), .vbr_in(vbr_in),
   .evt_a(evt_a), .evt_b(evt_b), .saved_sr(saved_sr), .saved_pc(saved_pc),
   .sr_new(sr_new), .fetch_addr(fetch_addr), .redirect(redirect)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        irq_req;
   logic [11:0] irq_code;
   logic        insn_brk;
   logic [31:0] sr_in, pc_next, vbr_in;
   logic [11:0] evt_a;
   logic [15:0] evt_b;
   logic [31:0] saved_sr, saved_pc, sr_new, fetch_addr;
   logic        redirect;

   int n_run  = 0;
   int n_fail = 0;

   logic        m_redir;
   logic [11:0] m_evt;
   logic [31:0] m_ssr, m_spc, m_snew, m_fetch;

   always #2 clk = ~clk;

   irq_entry_seq u_dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_code(irq_code),
      .insn_brk(insn_brk), .sr_in(sr_in), .pc_next(pc_next), .vbr_in(vbr_in),
      .evt_a(evt_a), .evt_b(evt_b), .saved_sr(saved_sr), .saved_pc(saved_pc),
      .sr_new(sr_new), .fetch_addr(fetch_addr), .redirect(redirect)
   );

   function automatic logic [31:0] exp_status(input logic [31:0] s);
      return s | 32'h7000_0000;
   endfunction

   function automatic logic [31:0] exp_vector(input logic [31:0] v);
      return v + 32'h0000_0600;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input string rtag, input logic req, input logic brk,
                       input logic [11:0] code, input logic [31:0] sr,
                       input logic [31:0] pc, input logic [31:0] vbr);
      logic tk;
      @(negedge clk);
      irq_req = req; insn_brk = brk; irq_code = code;
      sr_in = sr; pc_next = pc; vbr_in = vbr;
      tk = !m_redir && req && brk && !sr[28];
      m_redir = tk;
      if (tk) begin
         m_evt = code; m_ssr = sr; m_spc = pc;
         m_snew = exp_status(sr); m_fetch = exp_vector(vbr);
      end
      @(posedge clk); #1;
      chk({rtag, " redirect"}, {31'd0, redirect}, {31'd0, m_redir});
      chk("R4 evt_a", {20'd0, evt_a}, {20'd0, m_evt});
      chk("R4 evt_b", {16'd0, evt_b}, {20'd0, m_evt});
      chk("R5 saved_sr", saved_sr, m_ssr);
      chk("R5 saved_pc", saved_pc, m_spc);
      chk("R6 sr_new", sr_new, m_snew);
      chk("R7 fetch_addr", fetch_addr, m_fetch);
      if (!tk) chk("R9 hold pc", saved_pc, m_spc);
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; irq_req = 1'b0; insn_brk = 1'b0; irq_code = '0;
      sr_in = '0; pc_next = '0; vbr_in = '0;
      m_redir = 1'b0; m_evt = '0; m_ssr = '0; m_spc = '0; m_snew = '0; m_fetch = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 redirect", {31'd0, redirect}, 32'd0);
      chk("R1 saved_sr", saved_sr, 32'd0);
      chk("R1 fetch_addr", fetch_addr, 32'd0);
      chk("R1 evt_b", {16'd0, evt_b}, 32'd0);
      @(negedge clk); rst_n = 1'b1;

      // R3: request waits while no boundary
      repeat (3) step("R3", 1'b1, 1'b0, 12'h1A0, 32'h0000_00F0, 32'h8000_1000, 32'h8C00_0000);
      // R2 entry with mask field nonzero (R6 keeps it)
      step("R2", 1'b1, 1'b1, 12'h1A0, 32'h0000_00F0, 32'h8000_1000, 32'h8C00_0000);
      // R2: request during redirect cycle not taken
      step("R2", 1'b1, 1'b1, 12'h2C0, 32'h0000_0050, 32'h8000_2000, 32'h8C00_1000);
      // R8: block bit set blocks entry
      repeat (2) step("R8", 1'b1, 1'b1, 12'h3E0, 32'h1000_0030, 32'h8000_3000, 32'h0);
      // R7: vector wraps at 2^32; R4 max code
      step("R7", 1'b1, 1'b1, 12'hFFF, 32'h0000_0000, 32'hFFFF_FFFC, 32'hFFFF_FC00);
      step("R9", 1'b0, 1'b1, 12'h000, 32'h0, 32'h0, 32'h0);
      // R6: bits already set stay set, rest untouched
      step("R6", 1'b1, 1'b1, 12'h400, 32'h6FFF_FFFF, 32'h1234_5678, 32'h0000_0100);
      step("R9", 1'b0, 1'b0, 12'h000, 32'h0, 32'h0, 32'h0);

      for (int i = 0; i < 400; i++) begin
         logic [31:0] s;
         s = $urandom;
         if (($urandom % 4) != 0) s[28] = 1'b0;
         step("R2", ($urandom % 3) != 0, ($urandom % 2) != 0, 12'($urandom),
              s, $urandom, $urandom);
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule